// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the privileged machine-control registers of one processor thread behind a single indexed access port. An access names an index, a direction and, for writes, 64 bits of data. Each register applies its own shaping to written data. Depending on the register, the written value is kept in full, trimmed to a field mask, has a fixed bit forced low, or is cleared whatever the data. Read data comes back one clock after the request.

The bank also runs a free-running 32-bit cycle counter. A read of the cycle register returns its stored upper half with the live count in its lower half. Two exception-status registers collect event bits posted by the core, and software clears them by writing to them. Write-only command indices do not store anything. A write to one of them fires a one-cycle strobe that a cache or translation-buffer controller elsewhere acts on.

The access is rejected, and the error flag pulses, in three cases: a read of a command index, a write to the read-only identity register, or any access to an index that is not mapped. A rejected access changes no state.

Top module: `ctlreg_bank`

## Requirements
- R1: While reset is held, every register clears to zero except three. The base register (0x10) loads parameter BASE_RESET (default 0x8000). The control register (0x11) loads 0x6. Scratch register CPUID_SLOT (default 7, index 0x07) loads the zero-extended `cpu_id`.
- R2: A write to the exception-address register (0x12) stores the data with bit 1 forced to zero.
- R3: The two asynchronous-trap registers (0x13 request, 0x14 enable) keep only data bits 3:0.
- R4: The priority-level register (0x15) keeps only data bits 4:0.
- R5: The current-mode (0x16) and alternate-mode (0x17) registers keep only data bits 4:3 (mask 0x18).
- R6: The software-interrupt register (0x18) keeps only the data bits under mask 0x7fff0.
- R7: The exception-summary (0x19) and exception-mask (0x1A) registers OR in `exc_sum_post` and `exc_mask_post` respectively on every clock. A write to either register clears it to zero whatever the data, and the clear wins over a post in the same cycle.
- R8: A read of the cycle register (0x1B) returns bits 63:32 as last written and bits 31:0 from a counter that clears in reset and then increases by one each clock.
- R9: A write to command index 0x20+k (k < NUM_CMD) sets `cmd_strobe` to a one-hot value with only bit k set, for exactly the one clock after the write. Otherwise `cmd_strobe` is zero.
- R10: A read of a command index, a write to the identity register (0x1C), or any access to an unmapped index raises `acc_err` for the one clock after the request. Such an access leaves `rd_valid` low, `rd_data` zero and all register state unchanged. Unmapped indices are scratch indices at or above NUM_SCRATCH, 0x1D to 0x1F, command indices at or above NUM_CMD, and 0x30 to 0x3F.
- R11: A legal read raises `rd_valid` and presents `rd_data` one clock after the request. Scratch registers 0x00+i (i < NUM_SCRATCH, default 8) keep all 64 written bits. The identity register (0x1C) always reads `cpu_id` zero-extended.

Ports and indices:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_id | input | CPUID_W | Processor identifier, loaded into one scratch register at reset and returned by the identity register |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Register index |
| req_wdata | input | 64 | Write data |
| exc_sum_post | input | 64 | Event bits ORed into the exception-summary register |
| exc_mask_post | input | 64 | Event bits ORed into the exception-mask register |
| rd_valid | output | 1 | Read data valid, one clock after a legal read |
| rd_data | output | 64 | Read data, zero when not valid |
| acc_err | output | 1 | Rejected access, one clock after the request |
| cmd_strobe | output | NUM_CMD | One-hot command pulse |

## Verification
The hardest situation to reach is a software clear of an exception register that lands in the same clock as a hardware post to it. A clear that loses to the post cannot be told apart from a clear that never happened unless both are applied together. The bench therefore drives the post on the same falling edge as the clearing write, then reads the register back on the next access and expects zero. The live counter has no known absolute value, so its behaviour is checked as the difference between two reads a known number of clocks apart.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  localparam int XLEN   = 64;
  localparam int ADDR_W = 6;
  localparam int LIVE_W = 32;

  // offsets inside the fixed window (index 0x10 + offset)
  localparam int OFS_BASE    = 0;
  localparam int OFS_MISC    = 1;
  localparam int OFS_EXCADDR = 2;
  localparam int OFS_ASTREQ  = 3;
  localparam int OFS_ASTEN   = 4;
  localparam int OFS_IPL     = 5;
  localparam int OFS_CURMODE = 6;
  localparam int OFS_ALTMODE = 7;
  localparam int OFS_SWINT   = 8;
  localparam int OFS_EXCSUM  = 9;
  localparam int OFS_EXCMASK = 10;
  localparam int OFS_CYCLE   = 11;
  localparam int OFS_IDENT   = 12;
  localparam int FIXED_STORED = 12;

  typedef enum logic [3:0] {
    WK_NONE, WK_PLAIN, WK_EXCADDR, WK_LOW4, WK_LOW5,
    WK_MODE, WK_SWINT, WK_CLEAR, WK_RDONLY, WK_CMD
  } wkind_e;

  typedef struct packed {
    logic   mapped;
    logic   can_rd;
    logic   can_wr;
    logic   is_cmd;
    wkind_e kind;
  } acc_t;

  function automatic wkind_e fixed_kind(input logic [3:0] ofs);
    case (int'(ofs))
      OFS_BASE, OFS_MISC, OFS_CYCLE: return WK_PLAIN;
      OFS_EXCADDR:                   return WK_EXCADDR;
      OFS_ASTREQ, OFS_ASTEN:         return WK_LOW4;
      OFS_IPL:                       return WK_LOW5;
      OFS_CURMODE, OFS_ALTMODE:      return WK_MODE;
      OFS_SWINT:                     return WK_SWINT;
      OFS_EXCSUM, OFS_EXCMASK:       return WK_CLEAR;
      default:                       return WK_NONE;
    endcase
  endfunction

  // value stored by a legal write, per register kind
  function automatic logic [XLEN-1:0] shape_write(input wkind_e k,
                                                  input logic [XLEN-1:0] d);
    case (k)
      WK_PLAIN:   return d;
      WK_EXCADDR: return d & ~64'h2;
      WK_LOW4:    return d & 64'hF;
      WK_LOW5:    return d & 64'h1F;
      WK_MODE:    return d & 64'h18;
      WK_SWINT:   return d & 64'h7FFF0;
      default:    return '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] merge_cycle(input logic [XLEN-1:0] stored,
                                                  input logic [LIVE_W-1:0] live);
    return {stored[XLEN-1:LIVE_W], live};
  endfunction

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
  import ctlreg_pkg::*;
#(
  parameter int NUM_SCRATCH = 8,
  parameter int NUM_CMD     = 4,
  parameter int SLOT_W      = 5,
  parameter int CMD_W       = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc,
  output logic [SLOT_W-1:0] slot,
  output logic [CMD_W-1:0]  cmd_idx
);

  logic [1:0] win;
  logic [3:0] sub;

  assign win = addr[5:4];
  assign sub = addr[3:0];

  always_comb begin
    acc     = '{mapped: 1'b0, can_rd: 1'b0, can_wr: 1'b0, is_cmd: 1'b0, kind: WK_NONE};
    slot    = '0;
    cmd_idx = '0;
    case (win)
      2'd0: begin
        if (int'(sub) < NUM_SCRATCH) begin
          acc  = '{mapped: 1'b1, can_rd: 1'b1, can_wr: 1'b1, is_cmd: 1'b0, kind: WK_PLAIN};
          slot = SLOT_W'(int'(sub));
        end
      end
      2'd1: begin
        if (int'(sub) < FIXED_STORED) begin
          acc  = '{mapped: 1'b1, can_rd: 1'b1, can_wr: 1'b1, is_cmd: 1'b0,
                   kind: fixed_kind(sub)};
          slot = SLOT_W'(NUM_SCRATCH + int'(sub));
        end else if (int'(sub) == OFS_IDENT) begin
          acc = '{mapped: 1'b1, can_rd: 1'b1, can_wr: 1'b0, is_cmd: 1'b0, kind: WK_RDONLY};
        end
      end
      2'd2: begin
        if (int'(sub) < NUM_CMD) begin
          acc     = '{mapped: 1'b1, can_rd: 1'b0, can_wr: 1'b1, is_cmd: 1'b1, kind: WK_CMD};
          cmd_idx = CMD_W'(int'(sub));
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ctlreg_cyc_ctr.sv
module ctlreg_cyc_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + W'(1);
  end

endmodule

// File: rtl/ctlreg_store.sv
module ctlreg_store
  import ctlreg_pkg::*;
#(
  parameter int              NUM_SCRATCH = 8,
  parameter int              CPUID_W     = 8,
  parameter int              CPUID_SLOT  = 7,
  parameter logic [XLEN-1:0] BASE_RESET  = 64'h8000,
  parameter int              NUM_SLOTS   = 20,
  parameter int              SLOT_W      = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [CPUID_W-1:0]             cpu_id,
  input  logic                           wr_fire,
  input  logic [SLOT_W-1:0]              wr_slot,
  input  wkind_e                         wr_kind,
  input  logic [XLEN-1:0]                wr_data,
  input  logic [XLEN-1:0]                sum_post,
  input  logic [XLEN-1:0]                mask_post,
  output logic [NUM_SLOTS-1:0][XLEN-1:0] slots_q
);

  localparam int SLOT_BASE = NUM_SCRATCH + OFS_BASE;
  localparam int SLOT_MISC = NUM_SCRATCH + OFS_MISC;
  localparam int SLOT_SUM  = NUM_SCRATCH + OFS_EXCSUM;
  localparam int SLOT_MSK  = NUM_SCRATCH + OFS_EXCMASK;

  function automatic logic [XLEN-1:0] reset_const(input int g);
    if (g == SLOT_BASE) return BASE_RESET;
    if (g == SLOT_MISC) return 64'h6;
    return '0;
  endfunction

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [XLEN-1:0] rst_val;
    logic [XLEN-1:0] post;
    logic            hit;

    if (g == CPUID_SLOT) begin : g_id
      assign rst_val = XLEN'(cpu_id);
    end else begin : g_const
      assign rst_val = reset_const(g);
    end

    if (g == SLOT_SUM) begin : g_psum
      assign post = sum_post;
    end else if (g == SLOT_MSK) begin : g_pmsk
      assign post = mask_post;
    end else begin : g_pnone
      assign post = '0;
    end

    assign hit = wr_fire && (wr_slot == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)   slots_q[g] <= rst_val;
      else if (hit) slots_q[g] <= shape_write(wr_kind, wr_data);
      else          slots_q[g] <= slots_q[g] | post;
    end
  end

endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int              NUM_SCRATCH = 8,
  parameter int              NUM_CMD     = 4,
  parameter int              CPUID_W     = 8,
  parameter int              CPUID_SLOT  = 7,
  parameter logic [XLEN-1:0] BASE_RESET  = 64'h8000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CPUID_W-1:0] cpu_id,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [5:0]         req_addr,
  input  logic [63:0]        req_wdata,
  input  logic [63:0]        exc_sum_post,
  input  logic [63:0]        exc_mask_post,
  output logic               rd_valid,
  output logic [63:0]        rd_data,
  output logic               acc_err,
  output logic [NUM_CMD-1:0] cmd_strobe
);

  localparam int NUM_SLOTS    = NUM_SCRATCH + FIXED_STORED;
  localparam int SLOT_W       = $clog2(NUM_SLOTS);
  localparam int CMD_W        = (NUM_CMD > 1) ? $clog2(NUM_CMD) : 1;
  localparam int SLOT_CYC     = NUM_SCRATCH + OFS_CYCLE;
  localparam int SLOT_IPL     = NUM_SCRATCH + OFS_IPL;
  localparam int SLOT_EXCADDR = NUM_SCRATCH + OFS_EXCADDR;
  localparam int SLOT_SUM     = NUM_SCRATCH + OFS_EXCSUM;

  acc_t                           acc;
  logic [SLOT_W-1:0]              slot;
  logic [CMD_W-1:0]               cmd_idx;
  logic [NUM_SLOTS-1:0][XLEN-1:0] slots;
  logic [LIVE_W-1:0]              cyc_now;

  // named events for the checker
  logic            rd_ok, wr_ok, wr_fire, cmd_fire, bad_access, sum_clear_ev;
  logic [XLEN-1:0] ipl_q, exc_addr_q, exc_sum_q;
  logic [XLEN-1:0] rd_mux;
  logic [NUM_CMD-1:0] strobe_d;

  ctlreg_decode #(
    .NUM_SCRATCH(NUM_SCRATCH), .NUM_CMD(NUM_CMD), .SLOT_W(SLOT_W), .CMD_W(CMD_W)
  ) u_dec (
    .addr(req_addr), .acc(acc), .slot(slot), .cmd_idx(cmd_idx)
  );

  ctlreg_cyc_ctr #(.W(LIVE_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .count(cyc_now)
  );

  assign rd_ok        = req_valid && !req_write && acc.can_rd;
  assign wr_ok        = req_valid &&  req_write && acc.can_wr;
  assign bad_access   = req_valid && !(rd_ok || wr_ok);
  assign wr_fire      = wr_ok && !acc.is_cmd;
  assign cmd_fire     = wr_ok &&  acc.is_cmd;
  assign sum_clear_ev = wr_fire && (slot == SLOT_W'(SLOT_SUM));

  ctlreg_store #(
    .NUM_SCRATCH(NUM_SCRATCH), .CPUID_W(CPUID_W), .CPUID_SLOT(CPUID_SLOT),
    .BASE_RESET(BASE_RESET), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id),
    .wr_fire(wr_fire), .wr_slot(slot), .wr_kind(acc.kind), .wr_data(req_wdata),
    .sum_post(exc_sum_post), .mask_post(exc_mask_post), .slots_q(slots)
  );

  assign ipl_q      = slots[SLOT_IPL];
  assign exc_addr_q = slots[SLOT_EXCADDR];
  assign exc_sum_q  = slots[SLOT_SUM];

  always_comb begin
    if (acc.kind == WK_RDONLY)             rd_mux = XLEN'(cpu_id);
    else if (slot == SLOT_W'(SLOT_CYC))    rd_mux = merge_cycle(slots[slot], cyc_now);
    else                                   rd_mux = slots[slot];
  end

  for (genvar c = 0; c < NUM_CMD; c++) begin : g_stb
    assign strobe_d[c] = cmd_fire && (cmd_idx == CMD_W'(c));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      acc_err    <= 1'b0;
      cmd_strobe <= '0;
    end else begin
      rd_valid   <= rd_ok;
      rd_data    <= rd_ok ? rd_mux : '0;
      acc_err    <= bad_access;
      cmd_strobe <= strobe_d;
    end
  end

endmodule

// File: rtl/ctlreg_bank_chk.sv
module ctlreg_bank_chk #(
  parameter int NUM_CMD = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic               rd_valid,
  input logic               acc_err,
  input logic [NUM_CMD-1:0] cmd_strobe,
  input logic [31:0]        cyc_now,
  input logic [63:0]        ipl_q,
  input logic [63:0]        exc_addr_q,
  input logic [63:0]        exc_sum_q,
  input logic               sum_clear_ev
);

  p_excaddr_bit1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_addr_q[1] == 1'b0);

  p_ipl_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ipl_q[63:5] == '0);

  p_sum_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sum_clear_ev |=> exc_sum_q == 64'd0);

  p_cyc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cyc_now == $past(cyc_now) + 32'd1);

  p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_strobe));

  p_strobe_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_strobe) |-> $past(req_valid && req_write));

  p_err_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(req_valid));

  p_rd_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && acc_err));

  p_rd_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write));

endmodule

bind ctlreg_bank ctlreg_bank_chk #(.NUM_CMD(NUM_CMD)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rd_valid(rd_valid), .acc_err(acc_err), .cmd_strobe(cmd_strobe),
  .cyc_now(cyc_now), .ipl_q(ipl_q), .exc_addr_q(exc_addr_q),
  .exc_sum_q(exc_sum_q), .sum_clear_ev(sum_clear_ev)
);

// File: tb/tb_ctlreg_bank.sv
`timescale 1ns/1ps
module tb_ctlreg_bank;

  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [7:0]  ID   = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cpu_id = ID;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [63:0] req_wdata = '0, exc_sum_post = '0, exc_mask_post = '0;
  logic        rd_valid, acc_err;
  logic [63:0] rd_data;
  logic [3:0]  cmd_strobe;

  always #2 clk = ~clk;

  ctlreg_bank dut (
    .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .exc_sum_post(exc_sum_post), .exc_mask_post(exc_mask_post),
    .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err), .cmd_strobe(cmd_strobe)
  );

  typedef struct {
    int          due;
    logic        rv;
    logic        err;
    logic [63:0] data;
    logic [63:0] mask;
    logic [3:0]  stb;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  logic [63:0] last_rd = '0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare one expected item per clock
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (rd_valid)  last_rd = rd_data;
      if (rd_valid !== it.rv || acc_err !== it.err || cmd_strobe !== it.stb ||
          ((rd_data & it.mask) !== (it.data & it.mask))) begin
        errors++;
        $display("FAIL %s: got rv=%0b err=%0b stb=%b data=%h, expected rv=%0b err=%0b stb=%b data=%h mask=%h",
                 it.tag, rd_valid, acc_err, cmd_strobe, rd_data,
                 it.rv, it.err, it.stb, it.data, it.mask);
      end
    end
  end

  task automatic access(input logic wr, input logic [5:0] a, input logic [63:0] d,
                        input logic erv, input logic eerr, input logic [63:0] edata,
                        input logic [63:0] emask, input logic [3:0] estb,
                        input logic [63:0] sp, input logic [63:0] mp, input string tag);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    exc_sum_post = sp; exc_mask_post = mp;
    it = '{due: cyc + 1, rv: erv, err: eerr, data: edata, mask: emask, stb: estb, tag: tag};
    sb_q.push_back(it);
  endtask

  task automatic idle(input logic [63:0] sp, input logic [63:0] mp);
    item_t it;
    @(negedge clk);
    req_valid = 1'b0; exc_sum_post = sp; exc_mask_post = mp;
    it = '{due: cyc + 1, rv: 1'b0, err: 1'b0, data: '0, mask: ALL1, stb: 4'b0, tag: "idle"};
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d, input string tag);
    access(1'b1, a, d, 1'b0, 1'b0, '0, ALL1, 4'b0, '0, '0, tag);
  endtask

  task automatic rd(input logic [5:0] a, input logic [63:0] e, input string tag);
    access(1'b0, a, '0, 1'b1, 1'b0, e, ALL1, 4'b0, '0, '0, tag);
  endtask

  task automatic bad(input logic w, input logic [5:0] a, input string tag);
    access(w, a, ALL1, 1'b0, 1'b1, '0, ALL1, 4'b0, '0, '0, tag);
  endtask

  task automatic flush();
    idle('0, '0);
    idle('0, '0);
  endtask

  initial begin
    logic [31:0] c0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    rd(6'h10, 64'h8000, "R1 base reset");
    rd(6'h11, 64'h6, "R1 control reset");
    rd(6'h07, 64'(ID), "R1 id scratch reset");
    rd(6'h12, 64'h0, "R1 other reset zero");
    rd(6'h19, 64'h0, "R1 summary reset zero");

    // R11 scratch full width, identity register, latency
    wr(6'h03, 64'hDEAD_BEEF_0123_4567, "R11 scratch write");
    rd(6'h03, 64'hDEAD_BEEF_0123_4567, "R11 scratch readback");
    rd(6'h1C, 64'(ID), "R11 identity");

    // R2 .. R6 field shaping
    wr(6'h12, ALL1, "R2 write");
    rd(6'h12, 64'hFFFF_FFFF_FFFF_FFFD, "R2 bit1 forced low");
    wr(6'h13, ALL1, "R3 req write");
    wr(6'h14, 64'h35, "R3 en write");
    rd(6'h13, 64'hF, "R3 request keeps 3:0");
    rd(6'h14, 64'h5, "R3 enable keeps 3:0");
    wr(6'h15, 64'hFF, "R4 write");
    rd(6'h15, 64'h1F, "R4 keeps 4:0");
    wr(6'h16, ALL1, "R5 cur write");
    wr(6'h17, 64'h0C, "R5 alt write");
    rd(6'h16, 64'h18, "R5 current mode mask");
    rd(6'h17, 64'h08, "R5 alternate mode mask");
    wr(6'h18, ALL1, "R6 write");
    rd(6'h18, 64'h7FFF0, "R6 swint mask");

    // R7 post, clear, clear-wins
    idle(64'h30, 64'h5);
    rd(6'h19, 64'h30, "R7 summary post");
    rd(6'h1A, 64'h5, "R7 mask post");
    wr(6'h1A, ALL1, "R7 mask clear write");
    rd(6'h1A, 64'h0, "R7 mask cleared");
    access(1'b1, 6'h19, ALL1, 1'b0, 1'b0, '0, ALL1, 4'b0, 64'h300, '0, "R7 clear with post");
    rd(6'h19, 64'h0, "R7 clear wins over post");

    // R8 cycle register
    wr(6'h1B, 64'hABCD_0000_FFFF_FFFF, "R8 write");
    access(1'b0, 6'h1B, '0, 1'b1, 1'b0, 64'hABCD_0000_0000_0000,
           64'hFFFF_FFFF_0000_0000, 4'b0, '0, '0, "R8 upper half");
    flush();
    c0 = last_rd[31:0];
    access(1'b0, 6'h1B, '0, 1'b1, 1'b0, 64'hABCD_0000_0000_0000,
           64'hFFFF_FFFF_0000_0000, 4'b0, '0, '0, "R8 upper half again");
    flush();
    checks++;
    if (last_rd[31:0] - c0 !== 32'd3) begin
      errors++;
      $display("FAIL R8 live count step: got %0d expected 3", last_rd[31:0] - c0);
    end

    // R9 command strobes
    access(1'b1, 6'h22, '0, 1'b0, 1'b0, '0, ALL1, 4'b0100, '0, '0, "R9 strobe bit2");
    idle('0, '0);
    access(1'b1, 6'h20, '0, 1'b0, 1'b0, '0, ALL1, 4'b0001, '0, '0, "R9 strobe bit0");
    access(1'b1, 6'h23, '0, 1'b0, 1'b0, '0, ALL1, 4'b1000, '0, '0, "R9 strobe bit3 back to back");
    idle('0, '0);

    // R10 illegal accesses
    bad(1'b0, 6'h21, "R10 read of command");
    bad(1'b1, 6'h1C, "R10 write to identity");
    rd(6'h1C, 64'(ID), "R10 identity unchanged");
    bad(1'b1, 6'h08, "R10 unmapped scratch write");
    bad(1'b0, 6'h1D, "R10 unmapped fixed read");
    bad(1'b1, 6'h24, "R10 unmapped command write");
    bad(1'b0, 6'h3F, "R10 unmapped top read");
    rd(6'h03, 64'hDEAD_BEEF_0123_4567, "R10 scratch untouched");
    flush();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule